// File: doc/BRIEF.md
# Automatic Retransmit Transmit Controller

This block sequences one acknowledged transmit transaction for a low-rate wireless radio. A start request begins the transaction. The controller asks an external channel-access engine whether the medium is free, then triggers the modulator to send the frame that is already in the transmit buffer. It then waits for an acknowledgement when the frame asks for one. A busy medium leads to another access attempt. An acknowledgement that does not arrive leads to a new attempt for the whole frame, this time starting with channel access again. Both kinds of retry are counted against limits set by the surrounding logic.

The backoff engine, the modulator and the buffer storage sit outside the block and talk to it through simple request/done pins. The block only reads the first frame-control octet, and only to learn whether an acknowledgement is wanted. It never writes to the buffer. A single-cycle completion pulse ends every transaction, and a three-bit status code stays valid after it until the next completion.

Top module: `aret_tx_ctrl`

## Requirements
- R1: When idle, a transaction starts on a `start_cmd` pulse or on a low-to-high change of `start_pin`, and `busy` goes high. A `start_pin` held high does not start a second transaction after completion.
- R2: Each attempt begins with a one-cycle `csma_req`. A `csma_done` with `csma_idle` high leads to a one-cycle `tx_go`.
- R3: A `csma_done` with `csma_idle` low raises `csma_retry_cnt` by one and issues a new `csma_req`, up to `cfg_max_csma` retries. A busy report when the count already equals `cfg_max_csma` ends the transaction with status 3 (channel access failure).
- R4: On `tx_done`, if bit 5 of `fc_octet` is 0, the transaction ends with status 0 (success).
- R5: If that bit is 1, `rx_ack_en` goes high. An `ack_valid` pulse while `rx_ack_en` is high ends the transaction with status 1 when `ack_pending` is high, and with status 0 when it is low.
- R6: While `rx_ack_en` is high, the acknowledgement wait expires on the ACK_SYMS-th `sym_tick` pulse (54 by default) and not before.
- R7: On expiry, if `frame_retry_cnt` is below `cfg_max_frame`, the frame count rises by one, `csma_retry_cnt` returns to 0 and a new `csma_req` follows. Otherwise the transaction ends with status 5 (no acknowledgement).
- R8: `done` is high for exactly one cycle per transaction, and `busy` is low after it. `status` keeps its value until the next completion. After reset, `status` is 7 (invalid), `done` and `busy` are 0, and both retry counters are 0.
- R9: `ack_valid` and `tx_done` pulses that arrive while the controller is waiting for channel access have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_max_csma | input | CSMA_W | Channel-access retry limit |
| cfg_max_frame | input | FRAME_W | Frame retry limit |
| start_cmd | input | 1 | Start request pulse |
| start_pin | input | 1 | Start request, acts on its rising edge |
| fc_octet | input | FC_W | First frame-control octet of the buffered frame |
| csma_req | output | 1 | Request one channel-access attempt |
| csma_done | input | 1 | Channel-access attempt finished |
| csma_idle | input | 1 | With csma_done: channel clear |
| tx_go | output | 1 | Start sending the buffered frame |
| tx_done | input | 1 | Frame sent |
| rx_ack_en | output | 1 | Receiver armed for the acknowledgement |
| ack_valid | input | 1 | Matching, error-free acknowledgement received |
| ack_pending | input | 1 | Frame-pending flag of that acknowledgement |
| sym_tick | input | 1 | One pulse per symbol period |
| busy | output | 1 | Transaction in progress |
| csma_retry_cnt | output | CSMA_W | Channel-access retries in the current attempt |
| frame_retry_cnt | output | FRAME_W | Frame retries so far |
| done | output | 1 | Completion pulse |
| status | output | 3 | Termination code |

## Verification
The bench aims at the limits of both loops. It tests a channel that is busy exactly `cfg_max_csma` times and then clear, which must still transmit, and one busy time more, which must fail. A design with an off-by-one limit would give the wrong status code in one of these two cases. It gives 53 symbol ticks and then the 54th, so an early or late timeout shows up as `rx_ack_en` falling at the wrong moment. It also checks that the channel-access count starts again from zero on each frame retry. Stray acknowledgement and transmit-done pulses during channel access would produce a false completion in a design that did not gate them by state. A `start_pin` left high would restart a design that reacts to the level rather than the edge.

// File: rtl/aret_pkg.sv
package aret_pkg;

  typedef enum logic [2:0] {
    ST_SUCCESS      = 3'd0,
    ST_SUCCESS_PEND = 3'd1,
    ST_CHAN_FAIL    = 3'd3,
    ST_NO_ACK       = 3'd5,
    ST_INVALID      = 3'd7
  } aret_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CCA_REQ,
    S_CCA_WAIT,
    S_TX_REQ,
    S_TX_WAIT,
    S_ACK_WAIT
  } aret_state_e;

  localparam int ACK_REQ_BIT = 5;

  // Completion code for a received acknowledgement.
  function automatic aret_status_e ack_code(input logic pending);
    return pending ? ST_SUCCESS_PEND : ST_SUCCESS;
  endfunction

  // True when another retry would go past the configured limit.
  function automatic logic limit_hit(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/aret_start_detect.sv
module aret_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic start_cmd,
  input  logic start_pin,
  output logic start_evt
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= start_pin;
  end

  assign start_evt = start_cmd | (start_pin & ~pin_q);
endmodule

// File: rtl/aret_retry_cnt.sv
module aret_retry_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_limit
);
  import aret_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_limit = limit_hit(int'(cnt), int'(limit));

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (cnt != '0)); // R3
endmodule

// File: rtl/aret_ack_timer.sv
module aret_ack_timer #(
  parameter int SYMS = 54
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(SYMS + 1);
  localparam logic [CW-1:0] LAST = CW'(SYMS - 1);

  logic [CW-1:0] cnt;

  assign expired = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || expired)  cnt <= '0;
    else if (tick)             cnt <= cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(SYMS)); // R6
endmodule

// File: rtl/aret_tx_ctrl.sv
module aret_tx_ctrl #(
  parameter int CSMA_W   = 3,
  parameter int FRAME_W  = 4,
  parameter int FC_W     = 8,
  parameter int ACK_SYMS = 54
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CSMA_W-1:0]  cfg_max_csma,
  input  logic [FRAME_W-1:0] cfg_max_frame,
  input  logic               start_cmd,
  input  logic               start_pin,
  input  logic [FC_W-1:0]    fc_octet,
  output logic               csma_req,
  input  logic               csma_done,
  input  logic               csma_idle,
  output logic               tx_go,
  input  logic               tx_done,
  output logic               rx_ack_en,
  input  logic               ack_valid,
  input  logic               ack_pending,
  input  logic               sym_tick,
  output logic               busy,
  output logic [CSMA_W-1:0]  csma_retry_cnt,
  output logic [FRAME_W-1:0] frame_retry_cnt,
  output logic               done,
  output logic [2:0]         status
);
  import aret_pkg::*;

  aret_state_e  state_q, state_d;
  aret_status_e status_q, fin_code;
  logic done_q, fin;
  logic start_evt, ack_expired;
  logic csma_clr, csma_inc, csma_at_max;
  logic frm_clr, frm_inc, frm_at_max;
  logic want_ack;

  assign want_ack = fc_octet[ACK_REQ_BIT];

  aret_start_detect u_start (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd),
    .start_pin(start_pin), .start_evt(start_evt)
  );

  aret_retry_cnt #(.W(CSMA_W)) u_csma_cnt (
    .clk(clk), .rst_n(rst_n), .clr(csma_clr), .inc(csma_inc),
    .limit(cfg_max_csma), .cnt(csma_retry_cnt), .at_limit(csma_at_max)
  );

  aret_retry_cnt #(.W(FRAME_W)) u_frame_cnt (
    .clk(clk), .rst_n(rst_n), .clr(frm_clr), .inc(frm_inc),
    .limit(cfg_max_frame), .cnt(frame_retry_cnt), .at_limit(frm_at_max)
  );

  aret_ack_timer #(.SYMS(ACK_SYMS)) u_ack_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_ACK_WAIT),
    .tick(sym_tick), .expired(ack_expired)
  );

  always_comb begin
    state_d  = state_q;
    csma_clr = 1'b0;
    csma_inc = 1'b0;
    frm_clr  = 1'b0;
    frm_inc  = 1'b0;
    fin      = 1'b0;
    fin_code = status_q;
    unique case (state_q)
      S_IDLE: if (start_evt) begin
        state_d  = S_CCA_REQ;
        csma_clr = 1'b1;
        frm_clr  = 1'b1;
      end
      S_CCA_REQ: state_d = S_CCA_WAIT;
      S_CCA_WAIT: if (csma_done) begin
        if (csma_idle)        state_d = S_TX_REQ;
        else if (csma_at_max) begin fin = 1'b1; fin_code = ST_CHAN_FAIL; end
        else begin csma_inc = 1'b1; state_d = S_CCA_REQ; end
      end
      S_TX_REQ: state_d = S_TX_WAIT;
      S_TX_WAIT: if (tx_done) begin
        if (want_ack) state_d = S_ACK_WAIT;
        else begin fin = 1'b1; fin_code = ST_SUCCESS; end
      end
      S_ACK_WAIT: begin
        if (ack_valid) begin
          fin = 1'b1; fin_code = ack_code(ack_pending);
        end else if (ack_expired) begin
          if (frm_at_max) begin fin = 1'b1; fin_code = ST_NO_ACK; end
          else begin frm_inc = 1'b1; csma_clr = 1'b1; state_d = S_CCA_REQ; end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= ST_INVALID;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin) status_q <= fin_code;
    end
  end

  assign csma_req  = (state_q == S_CCA_REQ);
  assign tx_go     = (state_q == S_TX_REQ);
  assign rx_ack_en = (state_q == S_ACK_WAIT);
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign status    = status_q;

  AST_TXGO_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> $past(csma_done && csma_idle)); // R2
  AST_CHAN_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd3) |-> $past(csma_done && !csma_idle)); // R3
  AST_ACK_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack_en && ack_valid) |=> (done && !rx_ack_en)); // R5
  AST_NOACK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd5) |-> $past(sym_tick)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

// File: tb/aret_tx_ctrl_bench.sv
module aret_tx_ctrl_bench;
  localparam int CSMA_W = 3;
  localparam int FRAME_W = 4;
  localparam int NSYM = 54;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CSMA_W-1:0] cfg_max_csma = '0;
  logic [FRAME_W-1:0] cfg_max_frame = '0;
  logic start_cmd = 0, start_pin = 0, csma_done = 0, csma_idle = 0;
  logic tx_done = 0, ack_valid = 0, ack_pending = 0, sym_tick = 0;
  logic [7:0] fc_octet = '0;
  logic csma_req, tx_go, rx_ack_en, busy, done;
  logic [CSMA_W-1:0] csma_retry_cnt;
  logic [FRAME_W-1:0] frame_retry_cnt;
  logic [2:0] status;

  int nvec = 0, nfail = 0;
  int busy_n [0:16];
  bit ack_ok [0:16];
  bit pend   [0:16];

  always #5 clk = ~clk;

  aret_tx_ctrl u_aret_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_max_csma(cfg_max_csma), .cfg_max_frame(cfg_max_frame),
    .start_cmd(start_cmd), .start_pin(start_pin), .fc_octet(fc_octet),
    .csma_req(csma_req), .csma_done(csma_done), .csma_idle(csma_idle),
    .tx_go(tx_go), .tx_done(tx_done), .rx_ack_en(rx_ack_en), .ack_valid(ack_valid),
    .ack_pending(ack_pending), .sym_tick(sym_tick), .busy(busy),
    .csma_retry_cnt(csma_retry_cnt), .frame_retry_cnt(frame_retry_cnt),
    .done(done), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Outcome from the plan: status code, final frame count, final channel count.
  function automatic void predict(input int mc, input int mf, input bit ackreq,
                                  output int st, output int fr, output int cr);
    for (int a = 0; a <= mf; a++) begin
      if (busy_n[a] > mc) begin st = 3; fr = a; cr = mc; return; end
      if (!ackreq) begin st = 0; fr = a; cr = busy_n[a]; return; end
      if (ack_ok[a]) begin st = pend[a] ? 1 : 0; fr = a; cr = busy_n[a]; return; end
    end
    st = 5; fr = mf; cr = busy_n[mf];
  endfunction

  task automatic run_txn(input int mc, input int mf, input bit ackreq, input bit use_pin);
    int est, efr, ecr, attempt, nbusy, iter;
    bit fin;
    cfg_max_csma = CSMA_W'(mc);
    cfg_max_frame = FRAME_W'(mf);
    fc_octet = 8'($urandom_range(0, 255));
    fc_octet[5] = ackreq;
    predict(mc, mf, ackreq, est, efr, ecr);
    if (use_pin) start_pin = 1'b1; else start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
    chk(busy == 1'b1, "R1 start", int'(busy), 1);
    attempt = 0; nbusy = 0; fin = 0; iter = 0;
    while (!fin && iter < 40000) begin
      iter++;
      if (csma_req) begin
        chk(csma_retry_cnt == CSMA_W'(nbusy), "R3 csma count", int'(csma_retry_cnt), nbusy);
        chk(frame_retry_cnt == FRAME_W'(attempt), "R7 frame count", int'(frame_retry_cnt), attempt);
        ack_valid = 1'b1; tx_done = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0; tx_done = 1'b0;
        chk(!done && !tx_go && !rx_ack_en, "R9 stray ignored", int'(done), 0);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        csma_done = 1'b1;
        csma_idle = (nbusy >= busy_n[attempt]);
        if (!csma_idle) nbusy++;
        @(negedge clk);
        csma_done = 1'b0;
      end else if (tx_go) begin
        chk(!rx_ack_en, "R2 tx_go", int'(tx_go), 1);
        repeat ($urandom_range(1, 4)) @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
      end else if (rx_ack_en) begin
        if (ack_ok[attempt]) begin
          repeat ($urandom_range(0, 5)) begin
            sym_tick = 1'b1; @(negedge clk); sym_tick = 1'b0; @(negedge clk);
          end
          ack_pending = pend[attempt];
          ack_valid = 1'b1;
          @(negedge clk);
          ack_valid = 1'b0;
        end else begin
          for (int t = 0; t < NSYM - 1; t++) begin
            sym_tick = 1'b1; @(negedge clk); sym_tick = 1'b0;
            repeat ($urandom_range(0, 1)) @(negedge clk);
          end
          chk(rx_ack_en && !done, "R6 no early timeout", int'(rx_ack_en), 1);
          sym_tick = 1'b1; @(negedge clk); sym_tick = 1'b0;
          chk(!rx_ack_en, "R6 timeout on last tick", int'(rx_ack_en), 0);
          attempt++;
          nbusy = 0;
        end
      end else if (done) begin
        fin = 1;
        chk(status == 3'(est), "R3/R4/R5/R7 status", int'(status), est);
        chk(frame_retry_cnt == FRAME_W'(efr), "R7 final frame count", int'(frame_retry_cnt), efr);
        chk(csma_retry_cnt == CSMA_W'(ecr), "R3 final csma count", int'(csma_retry_cnt), ecr);
        @(negedge clk);
        chk(!done && !busy, "R8 single pulse", int'(done), 0);
        chk(status == 3'(est), "R8 status held", int'(status), est);
      end else begin
        @(negedge clk);
      end
    end
    if (!fin) chk(1'b0, "R8 no completion", 0, 1);
    if (use_pin) begin
      repeat (3) @(negedge clk);
      chk(!busy, "R1 level no retrigger", int'(busy), 0);
      start_pin = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic plan_all(input int busy_v, input bit ok_v, input bit pend_v);
    for (int a = 0; a <= 16; a++) begin busy_n[a] = busy_v; ack_ok[a] = ok_v; pend[a] = pend_v; end
  endtask

  initial begin
    void'($urandom(32'h0A4E7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 3'd7, "R8 reset status", int'(status), 7);
    chk(!done && !busy && !csma_req && !tx_go, "R8 reset idle", int'(busy), 0);
    chk(csma_retry_cnt == 0 && frame_retry_cnt == 0, "R8 reset counters", int'(csma_retry_cnt), 0);

    plan_all(1, 1, 0); run_txn(0, 0, 1, 0);          // R3 fail at zero limit
    plan_all(7, 1, 1); run_txn(7, 3, 1, 0);          // R3 limit exact, R5 pending
    plan_all(8, 1, 0); run_txn(7, 3, 0, 1);          // R3 one past limit, pin start
    plan_all(0, 0, 0); run_txn(2, 0, 1, 0);          // R7 no retry allowed
    plan_all(2, 0, 0); run_txn(3, 2, 1, 1);          // R7 all retries time out
    plan_all(0, 0, 0); ack_ok[2] = 1; pend[2] = 0;   // R5 ack on third try
    run_txn(1, 4, 1, 0);
    plan_all(3, 1, 0); run_txn(5, 1, 0, 0);          // R4 no ack wanted

    for (int n = 0; n < 40; n++) begin
      int mc, mf;
      mc = $urandom_range(0, 7);
      mf = $urandom_range(0, 4);
      for (int a = 0; a <= 16; a++) begin
        busy_n[a] = ($urandom_range(0, 9) == 0) ? mc + 1 : $urandom_range(0, mc);
        ack_ok[a] = ($urandom_range(0, 2) == 0);
        pend[a]   = $urandom_range(0, 1) == 1;
      end
      run_txn(mc, mf, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule